// File: doc/BRIEF.md
# Periodic Supply-Current Sampling Sequencer

This block runs one fixed-length session of supply-current readings while the device under test keeps executing its own pattern. A start pulse launches a loop of four steps: trigger a conversion on the current-measurement converters, wait, take the converted word, and store it in a local capture memory. Each store goes to the next address. Two test sites are converted at the same moment, one converter per site. Both readings come back as one raw word. That word is masked so only the two 12-bit fields survive, and it is written as a single capture entry.

The wait can be a fixed delay, which makes the sample period an exact number of clocks. It can also be "wait for conversion complete", where the period follows the converter's own timing. After the last sample the block writes an all-zero end marker and pulses done. While running it keeps a minimum, a maximum and a sum for each site. The mean is left to the consumer, which divides the sum by the sample count. With the default settings a session is 1000 samples of 712 clocks each. At a 60 ns clock that is 42.72 µs per sample and well under 50 ms per session.

Top module: `idd_sample_seq`

## Requirements
- R1: A start pulse while idle raises busy on the next clock edge, and adc_start is high in that same cycle. The base address and the wait mode are captured at that start.
- R2: With wait_rdy low at start, consecutive adc_start pulses are exactly PERIOD cycles apart. The store happens in the last cycle of each period, and adc_ready has no effect.
- R3: With wait_rdy high at start, the store happens in the cycle after the first wait cycle in which adc_ready is high. The trigger-to-trigger period is therefore 3 plus the number of wait cycles with adc_ready low.
- R4: Every stored sample equals adc_word AND 0x0FFF0FFF. Site A is in bits 11:0 and site B is in bits 27:16.
- R5: A session makes exactly SAMPLES sample writes, at base, base+1 and so on. The address wraps modulo 2^ADDR_W.
- R6: In the cycle right after the last sample write, an all-zero word is written at the next address.
- R7: done is high for exactly one cycle, the cycle after the end-marker write. busy stays high through that cycle and is low in the next one.
- R8: At done, min_a/max_a/sum_a and min_b/max_b/sum_b hold the minimum, maximum and sum of the stored site-A and site-B fields. They keep those values until the next start.
- R9: A start pulse while busy is ignored: the sample count, the addresses, the wait mode and the timing all continue unchanged.
- R10: After reset, and again at each start, the per-site minimum is 0xFFF and the per-site maximum and sum are 0. After reset busy, done, adc_start and mem_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session start request |
| wait_rdy | input | 1 | Wait mode, captured at start: 0 fixed delay, 1 wait for adc_ready |
| base_addr | input | ADDR_W | First capture address, captured at start |
| adc_start | output | 1 | Conversion trigger, one cycle per sample |
| adc_ready | input | 1 | Conversion-complete flag from the converters |
| adc_word | input | 32 | Raw two-site converter read word |
| mem_we | output | 1 | Capture memory write enable |
| mem_addr | output | ADDR_W | Capture memory write address |
| mem_wdata | output | 32 | Capture memory write data |
| busy | output | 1 | Session in progress |
| done | output | 1 | One-cycle end-of-session pulse |
| min_a | output | 12 | Site A running minimum |
| max_a | output | 12 | Site A running maximum |
| sum_a | output | SUM_W | Site A running sum |
| min_b | output | 12 | Site B running minimum |
| max_b | output | 12 | Site B running maximum |
| sum_b | output | SUM_W | Site B running sum |

## Verification
The first adc_start appears one edge after start is sampled. In fixed mode each store lands PERIOD-1 cycles after its trigger. In ready mode the store lands one cycle after the first wait cycle that sees adc_ready high. The end marker follows the last store by one cycle, done follows the end marker by one cycle, and busy falls one cycle after done. The bench keeps a cycle counter on the falling edge and compares the cycle number of each trigger, store, marker and done against the gap these rules predict. Statistics are compared against sums and extremes that the bench computes from the words its own converter model handed out.

// File: rtl/idd_sample_seq.sv
module idd_sample_seq #(
  parameter int SAMPLES = 1000,
  parameter int PERIOD  = 712,
  parameter int ADDR_W  = 10,
  parameter int FIELD_W = 12,
  parameter int HI_LSB  = 16,
  parameter logic [31:0] MASK = 32'h0FFF0FFF,
  localparam int CNT_W = $clog2(SAMPLES + 1),
  localparam int DLY_W = $clog2(PERIOD + 1),
  localparam int SUM_W = FIELD_W + $clog2(SAMPLES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               wait_rdy,
  input  logic [ADDR_W-1:0]  base_addr,
  output logic               adc_start,
  input  logic               adc_ready,
  input  logic [31:0]        adc_word,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [31:0]        mem_wdata,
  output logic               busy,
  output logic               done,
  output logic [FIELD_W-1:0] min_a,
  output logic [FIELD_W-1:0] max_a,
  output logic [SUM_W-1:0]   sum_a,
  output logic [FIELD_W-1:0] min_b,
  output logic [FIELD_W-1:0] max_b,
  output logic [SUM_W-1:0]   sum_b
);

  typedef enum logic [2:0] {S_IDLE, S_TRIG, S_WAIT, S_STORE, S_TERM, S_FIN} st_t;

  st_t               state;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [DLY_W-1:0]  dly_q;
  logic              mode_q;

  logic [31:0]        masked;
  logic [FIELD_W-1:0] fa, fb;
  logic               wait_over;

  assign masked    = adc_word & MASK;
  assign fa        = masked[FIELD_W-1:0];
  assign fb        = masked[HI_LSB +: FIELD_W];
  assign wait_over = mode_q ? adc_ready : (dly_q == DLY_W'(PERIOD - 3));

  assign adc_start = (state == S_TRIG);
  assign mem_we    = (state == S_STORE) || (state == S_TERM);
  assign mem_addr  = addr_q;
  assign mem_wdata = (state == S_STORE) ? masked : 32'd0;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      dly_q  <= '0;
      mode_q <= 1'b0;
      min_a  <= '1;
      max_a  <= '0;
      sum_a  <= '0;
      min_b  <= '1;
      max_b  <= '0;
      sum_b  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_TRIG;
          addr_q <= base_addr;
          left_q <= CNT_W'(SAMPLES);
          mode_q <= wait_rdy;
          min_a  <= '1;
          max_a  <= '0;
          sum_a  <= '0;
          min_b  <= '1;
          max_b  <= '0;
          sum_b  <= '0;
        end
        S_TRIG: begin
          state <= S_WAIT;
          dly_q <= '0;
        end
        S_WAIT: begin
          dly_q <= dly_q + 1'b1;
          if (wait_over) state <= S_STORE;
        end
        S_STORE: begin
          addr_q <= addr_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (fa < min_a) min_a <= fa;
          if (fa > max_a) max_a <= fa;
          if (fb < min_b) min_b <= fb;
          if (fb > max_b) max_b <= fb;
          sum_a <= sum_a + SUM_W'(fa);
          sum_b <= sum_b + SUM_W'(fb);
          state <= (left_q == CNT_W'(1)) ? S_TERM : S_TRIG;
        end
        S_TERM:  state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [DLY_W:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap_q <= '0;
    else if (adc_start)       gap_q <= (DLY_W+1)'(1);
    else if (!busy)           gap_q <= '0;
    else if (gap_q != '0)     gap_q <= gap_q + 1'b1;
  end

  assert_fixed_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start && gap_q != '0 && !mode_q |-> gap_q == (DLY_W+1)'(PERIOD));

  assert_trigger_on_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> adc_start);

  assert_done_after_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we) && $past(mem_wdata) == 32'd0);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) + 1'b1);

  assert_stat_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> min_a <= max_a && min_b <= max_b);

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode_q));

endmodule

// File: tb/idd_sample_seq_bench.sv
module idd_sample_seq_bench;
  localparam int SMP = 12;
  localparam int PER = 20;
  localparam int AW  = 10;
  localparam int SW  = 12 + $clog2(SMP);
  localparam logic [31:0] MSK = 32'h0FFF0FFF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wait_rdy = 1'b0, adc_ready = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [31:0] adc_word = '0;
  logic adc_start, mem_we, busy, done;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [11:0] min_a, max_a, min_b, max_b;
  logic [SW-1:0] sum_a, sum_b;

  always #4 clk = ~clk;

  idd_sample_seq #(.SAMPLES(SMP), .PERIOD(PER), .ADDR_W(AW)) u_idd_sample_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_rdy(wait_rdy), .base_addr(base_addr),
    .adc_start(adc_start), .adc_ready(adc_ready), .adc_word(adc_word),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .min_a(min_a), .max_a(max_a), .sum_a(sum_a),
    .min_b(min_b), .max_b(max_b), .sum_b(sum_b));

  int total = 0, bad = 0;
  int cyc = 0, last_trig = 0, ntrig = 0, nwr = 0, last_store = 0, term_cyc = -10;
  int exp_gap = 0, kwait = 0, wcnt = 0, done_cnt = 0, pat = 0;
  logic [AW-1:0] exp_base = '0;
  logic exp_mode = 1'b0, prev_done = 1'b0;
  logic [31:0] words [SMP];

  task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] gen_word(input int p);
    if (p == 1) return 32'hFFFF_FFFF;
    if (p == 2) return 32'h0000_0000;
    return $urandom;
  endfunction

  task automatic check_stats();
    logic [11:0] mna = 12'hFFF, mxa = 0, mnb = 12'hFFF, mxb = 0;
    logic [SW-1:0] sa = 0, sb = 0;
    for (int i = 0; i < SMP; i++) begin
      logic [31:0] m = words[i] & MSK;
      if (m[11:0] < mna) mna = m[11:0];
      if (m[11:0] > mxa) mxa = m[11:0];
      if (m[27:16] < mnb) mnb = m[27:16];
      if (m[27:16] > mxb) mxb = m[27:16];
      sa = sa + SW'(m[11:0]);
      sb = sb + SW'(m[27:16]);
    end
    chk(min_a == mna, "R8 min_a", min_a, mna);
    chk(max_a == mxa, "R8 max_a", max_a, mxa);
    chk(sum_a == sa,  "R8 sum_a", sum_a, sa);
    chk(min_b == mnb && max_b == mxb && sum_b == sb, "R8 site b",
        {min_b, max_b, sum_b}, {mnb, mxb, sb});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      if (prev_done) chk(!done && !busy, "R7 done width/busy fall", {done, busy}, 0);
      prev_done = done;
      if (adc_start) begin
        if (ntrig > 0) begin
          if (!exp_mode) chk(cyc - last_trig == PER, "R2 period", cyc - last_trig, PER);
          else chk(cyc - last_trig == exp_gap, "R3 period", cyc - last_trig, exp_gap);
        end
        last_trig = cyc;
        if (ntrig < SMP) words[ntrig] = gen_word(pat);
        adc_word = words[ntrig < SMP ? ntrig : SMP-1];
        ntrig++;
        adc_ready = 1'b0;
        kwait = $urandom % 5;
        exp_gap = kwait + 3;
        wcnt = 0;
      end else if (busy && !mem_we && !done) begin
        if (exp_mode) begin
          if (wcnt == kwait) adc_ready = 1'b1;
          wcnt++;
        end else adc_ready = $urandom;
      end
      if (mem_we) begin
        if (nwr < SMP) begin
          chk(mem_addr == AW'(exp_base + nwr), "R5 address", mem_addr, AW'(exp_base + nwr));
          chk(mem_wdata == (words[nwr] & MSK), "R4 masked word", mem_wdata, words[nwr] & MSK);
          if (!exp_mode) chk(cyc - last_trig == PER - 1, "R2 store slot", cyc - last_trig, PER - 1);
          nwr++;
          last_store = cyc;
        end else begin
          chk(mem_wdata == 0 && mem_addr == AW'(exp_base + SMP), "R6 end marker",
              {mem_addr, mem_wdata}, {AW'(exp_base + SMP), 32'd0});
          chk(cyc == last_store + 1, "R6 marker timing", cyc, last_store + 1);
          term_cyc = cyc;
          nwr++;
        end
      end
      if (done) begin
        chk(cyc == term_cyc + 1, "R7 done timing", cyc, term_cyc + 1);
        chk(nwr == SMP + 1, "R5 write count", nwr, SMP + 1);
        check_stats();
        done_cnt++;
      end
    end
  end

  task automatic session(input logic [AW-1:0] b, input logic m, input int p, input bit poke);
    int d0;
    @(negedge clk);
    ntrig = 0; nwr = 0; pat = p; exp_base = b; exp_mode = m;
    base_addr = b; wait_rdy = m; start = 1'b1;
    d0 = done_cnt;
    @(negedge clk);
    start = 1'b0;
    base_addr = ~b;
    wait_rdy = ~m;
    chk(busy && adc_start, "R1 start response", {busy, adc_start}, 2'b11);
    chk(min_a == 12'hFFF && max_a == 0 && sum_a == 0, "R10 stats cleared at start",
        {min_a, max_a, sum_a}, {12'hFFF, 12'd0, SW'(0)});
    if (poke) begin
      repeat (PER + 7) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(min_a == 12'hFFF || min_a <= max_a, "R8 stats held after done", min_a, max_a);
    chk(!busy, "R9 no restart from ignored start", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !adc_start && !mem_we, "R10 reset outputs",
        {busy, done, adc_start, mem_we}, 0);
    chk(min_a == 12'hFFF && max_a == 0 && sum_a == 0 && min_b == 12'hFFF,
        "R10 reset stats", {min_a, max_a, sum_a}, {12'hFFF, 12'd0, SW'(0)});
    rst_n = 1'b1;
    void'($urandom(32'd7));
    session(10'd5,    1'b0, 0, 1'b0);
    session(10'd1018, 1'b0, 1, 1'b0);
    session(10'd300,  1'b1, 2, 1'b0);
    session(10'd40,   1'b1, 0, 1'b1);
    session(10'd700,  1'b0, 0, 1'b1);
    for (int i = 0; i < 3; i++) session(AW'($urandom), 1'($urandom), 0, 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule